// File: doc/BRIEF.md
# Token-Passing Transmit Handshake Sequencer

This block runs the transmit side of one node on a deterministic token-passing network. The host loads a destination node ID and issues a transmit-enable command. The block keeps that request until it next holds the token. With no request pending, a token arrival is handed straight on with a one-cycle pass-token request. With a request pending, the block first sends a free-buffer enquiry to the destination and then listens for a reply. An ACK makes it send the data frame, after which it waits for a final acknowledgement. A NAK makes it give up the token without sending any data.

A single reply timer guards both listening windows. The window starts when the frame-send interface reports that the frame has left. If no reply arrives before the timer runs out, the block takes the no-response path. Four sticky status bits record whether the block is free for a new request and how the last attempt ended. A per-bit mask turns any of those bits into a level interrupt for the processor. Line coding, the CRC datapath and network reconfiguration belong to neighbouring blocks.

Top module: `txseq_top`

## Requirements
- R1: After reset the status word is 4'b0001 (bit0 = transmit available, bit1 = delivered, bit2 = no response, bit3 = refused), none of sendEnq, sendData or passToken is high, and irq is low when intMask is zero.
- R2: A txEnable pulse is accepted only while status bit0 is 1. Acceptance captures destId, clears all four status bits, and is visible one cycle later. A txEnable while bit0 is 0 is ignored: the status and the captured destination stay unchanged.
- R3: A tokenIn pulse with no accepted request pending gives a one-cycle passToken one cycle later and no enquiry. This includes a txEnable that arrives in the same cycle as tokenIn: that request stays pending for the next token.
- R4: A tokenIn pulse with a request pending gives a one-cycle sendEnq one cycle later, with frameDest equal to the captured destination ID (8 bits). frameDest holds that value until the sequence ends.
- R5: The cycle in which frameDone is sampled during an enquiry opens the enquiry reply window. A replyAck sampled inside that window gives a one-cycle sendData one cycle later.
- R6: A replyNak in the enquiry window gives passToken one cycle later. No sendData is issued, and the status becomes 4'b1001.
- R7: A replyAck in the window after the data frame gives passToken one cycle later, and the status becomes 4'b0011.
- R8: A window counts REPLY_TIMEOUT sampled cycles after the frameDone cycle, and a reply in the last of those cycles is still taken. If no reply arrives in either window, passToken follows the cycle after the last window cycle, and the status becomes 4'b0101. Before that cycle there is no passToken.
- R9: irq is high exactly while some status bit and the intMask bit at the same position are both 1.
- R10: A replyAck or replyNak is ignored outside a reply window: when the block is idle, and during a frame before its frameDone. It causes no request and no status change.
- R11: At most one of sendEnq, sendData and passToken is high in any cycle, and each is a single-cycle pulse per event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tokenIn | input | 1 | Strobe: this node now holds the token |
| txEnable | input | 1 | Strobe: host command to transmit the loaded packet |
| destId | input | ID_W | Destination node ID captured with txEnable |
| replyAck | input | 1 | Strobe: ACK frame decoded from the line |
| replyNak | input | 1 | Strobe: NAK frame decoded from the line |
| frameDone | input | 1 | Strobe: the requested frame has been fully sent |
| intMask | input | 4 | Per-status-bit interrupt enable |
| sendEnq | output | 1 | Request: send a free-buffer enquiry to frameDest |
| sendData | output | 1 | Request: send the data packet with its CRC to frameDest |
| passToken | output | 1 | Request: pass the token to the next node |
| frameDest | output | ID_W | Destination ID for the requested frame |
| statusOut | output | 4 | Status bits: available, delivered, no response, refused |
| irq | output | 1 | Masked status interrupt |

## Verification
A host command and a token arrival can land in the same cycle. The bench drives txEnable and tokenIn together at one edge and expects the token decision to use the request state from before that edge. It checks that passToken comes out with no enquiry, that bit0 drops, and that the next token starts the enquiry to the newly captured ID. A reply that lands in the last cycle of a window meets the timer expiry in the same cycle. Here the bench places the ACK exactly on cycle REPLY_TIMEOUT and expects sendData, not the no-response path.

// File: rtl/txseq_pkg.sv
package txseq_pkg;

  localparam int STATUS_W = 4;
  localparam int ST_AVAIL = 0;
  localparam int ST_OK = 1;
  localparam int ST_FAIL = 2;
  localparam int ST_REFUSED = 3;

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_ENQ_SEND,
    SEQ_ENQ_WAIT,
    SEQ_DATA_SEND,
    SEQ_DATA_WAIT
  } seqState_t;

  typedef struct packed {
    logic loadTimer;
    logic runTimer;
    logic finish;
    logic markOk;
    logic markFail;
    logic markRefused;
  } seqStrobe_t;

endpackage

// File: rtl/txseq_dp.sv
module txseq_dp
  import txseq_pkg::*;
#(
  parameter int ID_W = 8,
  parameter int REPLY_TIMEOUT = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                txEnable,
  input  logic [ID_W-1:0]     destId,
  input  logic [STATUS_W-1:0] intMask,
  input  seqStrobe_t          strobe,
  output logic                txAvail,
  output logic                timerExpired,
  output logic [ID_W-1:0]     frameDest,
  output logic [STATUS_W-1:0] statusOut,
  output logic                irq
);

  localparam int TIMER_W = $clog2(REPLY_TIMEOUT + 1);
  localparam logic [TIMER_W-1:0] TIMER_LOAD = TIMER_W'(REPLY_TIMEOUT - 1);

  logic [TIMER_W-1:0]  timerQ;
  logic [ID_W-1:0]     destQ;
  logic [STATUS_W-1:0] statusQ;
  logic                accept;

  assign accept = txEnable && statusQ[ST_AVAIL];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      timerQ <= '0;
    end else if (strobe.loadTimer) begin
      timerQ <= TIMER_LOAD;
    end else if (strobe.runTimer && timerQ != '0) begin
      timerQ <= timerQ - 1'b1;
    end
  end

  assign timerExpired = (timerQ == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      destQ <= '0;
    end else if (accept) begin
      destQ <= destId;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= STATUS_W'(1) << ST_AVAIL;
    end else if (accept) begin
      statusQ <= '0;
    end else if (strobe.finish) begin
      statusQ[ST_AVAIL]   <= 1'b1;
      statusQ[ST_OK]      <= statusQ[ST_OK] | strobe.markOk;
      statusQ[ST_FAIL]    <= statusQ[ST_FAIL] | strobe.markFail;
      statusQ[ST_REFUSED] <= statusQ[ST_REFUSED] | strobe.markRefused;
    end
  end

  assign txAvail   = statusQ[ST_AVAIL];
  assign frameDest = destQ;
  assign statusOut = statusQ;
  assign irq       = |(statusQ & intMask);

endmodule

// File: rtl/txseq_ctrl.sv
module txseq_ctrl
  import txseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tokenIn,
  input  logic       frameDone,
  input  logic       replyAck,
  input  logic       replyNak,
  input  logic       txAvail,
  input  logic       timerExpired,
  output seqStrobe_t strobe,
  output logic       sendEnq,
  output logic       sendData,
  output logic       passToken,
  output logic       busy
);

  seqState_t stateQ, stateD;
  logic enqD, dataD, passD;

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    enqD   = 1'b0;
    dataD  = 1'b0;
    passD  = 1'b0;
    unique case (stateQ)
      SEQ_IDLE: begin
        if (tokenIn) begin
          if (!txAvail) begin
            stateD = SEQ_ENQ_SEND;
            enqD   = 1'b1;
          end else begin
            passD = 1'b1;
          end
        end
      end
      SEQ_ENQ_SEND: begin
        if (frameDone) begin
          stateD           = SEQ_ENQ_WAIT;
          strobe.loadTimer = 1'b1;
        end
      end
      SEQ_ENQ_WAIT: begin
        strobe.runTimer = 1'b1;
        if (replyAck) begin
          stateD = SEQ_DATA_SEND;
          dataD  = 1'b1;
        end else if (replyNak) begin
          stateD             = SEQ_IDLE;
          passD              = 1'b1;
          strobe.finish      = 1'b1;
          strobe.markRefused = 1'b1;
        end else if (timerExpired) begin
          stateD          = SEQ_IDLE;
          passD           = 1'b1;
          strobe.finish   = 1'b1;
          strobe.markFail = 1'b1;
        end
      end
      SEQ_DATA_SEND: begin
        if (frameDone) begin
          stateD           = SEQ_DATA_WAIT;
          strobe.loadTimer = 1'b1;
        end
      end
      SEQ_DATA_WAIT: begin
        strobe.runTimer = 1'b1;
        if (replyAck) begin
          stateD        = SEQ_IDLE;
          passD         = 1'b1;
          strobe.finish = 1'b1;
          strobe.markOk = 1'b1;
        end else if (timerExpired) begin
          stateD          = SEQ_IDLE;
          passD           = 1'b1;
          strobe.finish   = 1'b1;
          strobe.markFail = 1'b1;
        end
      end
      default: stateD = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ    <= SEQ_IDLE;
      sendEnq   <= 1'b0;
      sendData  <= 1'b0;
      passToken <= 1'b0;
    end else begin
      stateQ    <= stateD;
      sendEnq   <= enqD;
      sendData  <= dataD;
      passToken <= passD;
    end
  end

  assign busy = (stateQ != SEQ_IDLE);

endmodule

// File: rtl/txseq_top.sv
module txseq_top
  import txseq_pkg::*;
#(
  parameter int ID_W = 8,
  parameter int REPLY_TIMEOUT = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tokenIn,
  input  logic                txEnable,
  input  logic [ID_W-1:0]     destId,
  input  logic                replyAck,
  input  logic                replyNak,
  input  logic                frameDone,
  input  logic [STATUS_W-1:0] intMask,
  output logic                sendEnq,
  output logic                sendData,
  output logic                passToken,
  output logic [ID_W-1:0]     frameDest,
  output logic [STATUS_W-1:0] statusOut,
  output logic                irq
);

  seqStrobe_t seqStrobe;
  logic       txAvail;
  logic       timerExpired;
  logic       ctrlBusy;

  txseq_ctrl uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .tokenIn      (tokenIn),
    .frameDone    (frameDone),
    .replyAck     (replyAck),
    .replyNak     (replyNak),
    .txAvail      (txAvail),
    .timerExpired (timerExpired),
    .strobe       (seqStrobe),
    .sendEnq      (sendEnq),
    .sendData     (sendData),
    .passToken    (passToken),
    .busy         (ctrlBusy)
  );

  txseq_dp #(
    .ID_W          (ID_W),
    .REPLY_TIMEOUT (REPLY_TIMEOUT)
  ) uDp (
    .clk          (clk),
    .rstN         (rstN),
    .txEnable     (txEnable),
    .destId       (destId),
    .intMask      (intMask),
    .strobe       (seqStrobe),
    .txAvail      (txAvail),
    .timerExpired (timerExpired),
    .frameDest    (frameDest),
    .statusOut    (statusOut),
    .irq          (irq)
  );

endmodule

// File: rtl/txseq_chk.sv
module txseq_chk #(
  parameter int ID_W = 8
) (
  input logic            clk,
  input logic            rstN,
  input logic            tokenIn,
  input logic            txEnable,
  input logic            replyAck,
  input logic            busy,
  input logic            sendEnq,
  input logic            sendData,
  input logic            passToken,
  input logic [ID_W-1:0] frameDest,
  input logic [3:0]      statusOut,
  input logic [3:0]      intMask,
  input logic            irq
);

  assert_req_exclusive_R11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({sendEnq, sendData, passToken}));

  assert_data_after_ack_R5: assert property (@(posedge clk) disable iff (!rstN)
    sendData |-> $past(replyAck));

  assert_accept_clears_avail_R2: assert property (@(posedge clk) disable iff (!rstN)
    (txEnable && statusOut[0]) |=> !statusOut[0]);

  assert_idle_token_pass_R3: assert property (@(posedge clk) disable iff (!rstN)
    (tokenIn && !busy && statusOut[0]) |=> (passToken && !sendEnq));

  assert_dest_stable_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(frameDest));

  assert_ok_needs_ack_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusOut[1]) |-> $past(replyAck));

  assert_mask_zero_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    (intMask == 4'b0000) |-> !irq);

  assert_refused_irq_R9: assert property (@(posedge clk) disable iff (!rstN)
    (statusOut[3] && intMask[3]) |-> irq);

endmodule

bind txseq_top txseq_chk #(.ID_W(ID_W)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .tokenIn   (tokenIn),
  .txEnable  (txEnable),
  .replyAck  (replyAck),
  .busy      (ctrlBusy),
  .sendEnq   (sendEnq),
  .sendData  (sendData),
  .passToken (passToken),
  .frameDest (frameDest),
  .statusOut (statusOut),
  .intMask   (intMask),
  .irq       (irq)
);

// File: tb/sim_txseq_top.sv
`timescale 1ns/1ps
module sim_txseq_top;

  localparam int T = 16;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tokenIn = 1'b0;
  logic       txEnable = 1'b0;
  logic [7:0] destId = '0;
  logic       replyAck = 1'b0;
  logic       replyNak = 1'b0;
  logic       frameDone = 1'b0;
  logic [3:0] intMask = '0;
  logic       sendEnq, sendData, passToken, irq;
  logic [7:0] frameDest;
  logic [3:0] statusOut;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  txseq_top #(.ID_W(8), .REPLY_TIMEOUT(T)) u0 (
    .clk(clk), .rstN(rstN), .tokenIn(tokenIn), .txEnable(txEnable),
    .destId(destId), .replyAck(replyAck), .replyNak(replyNak),
    .frameDone(frameDone), .intMask(intMask), .sendEnq(sendEnq),
    .sendData(sendData), .passToken(passToken), .frameDest(frameDest),
    .statusOut(statusOut), .irq(irq)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic startTx(input logic [7:0] id);
    txEnable = 1'b1; destId = id;
    tick();
    txEnable = 1'b0;
  endtask

  task automatic giveToken();
    tokenIn = 1'b1;
    tick();
    tokenIn = 1'b0;
  endtask

  task automatic frameSent();
    frameDone = 1'b1;
    tick();
    frameDone = 1'b0;
  endtask

  // reply sampled at window cycle j; returns just after that edge
  task automatic replyAt(input bit isAck, input int j);
    tick(j - 1);
    if (isAck) replyAck = 1'b1; else replyNak = 1'b1;
    tick();
    replyAck = 1'b0; replyNak = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "status", statusOut, 4'b0001);
    chk("R1", "requests", {sendEnq, sendData, passToken}, 3'b000);
    chk("R1", "irq", irq, 1'b0);
  endtask

  task automatic t_idlePass();
    giveToken();
    chk("R3", "passToken", passToken, 1'b1);
    chk("R3", "sendEnq", sendEnq, 1'b0);
    tick();
    chk("R11", "passToken pulse", passToken, 1'b0);
  endtask

  task automatic t_fullAck();
    intMask = 4'b0010;
    startTx(8'h5A);
    chk("R2", "status after accept", statusOut, 4'b0000);
    giveToken();
    chk("R4", "sendEnq", sendEnq, 1'b1);
    chk("R4", "frameDest", frameDest, 8'h5A);
    chk("R11", "no pass with enq", passToken, 1'b0);
    tick();
    chk("R11", "sendEnq pulse", sendEnq, 1'b0);
    frameSent();
    replyAt(1'b1, 3);
    chk("R5", "sendData", sendData, 1'b1);
    chk("R4", "frameDest held", frameDest, 8'h5A);
    frameSent();
    replyAt(1'b1, 2);
    chk("R7", "passToken", passToken, 1'b1);
    chk("R7", "status", statusOut, 4'b0011);
    chk("R9", "irq on delivered", irq, 1'b1);
    tick();
    intMask = 4'b0100; #1;
    chk("R9", "irq masked off", irq, 1'b0);
    intMask = 4'b0000;
  endtask

  task automatic t_enqNak();
    startTx(8'h11);
    giveToken();
    tick();
    frameSent();
    replyAt(1'b0, 1);
    chk("R6", "passToken", passToken, 1'b1);
    chk("R6", "no sendData", sendData, 1'b0);
    chk("R6", "status", statusOut, 4'b1001);
    intMask = 4'b1000; #1;
    chk("R9", "irq on refused", irq, 1'b1);
    intMask = 4'b0000;
    tick();
  endtask

  task automatic t_lastCycleAck();
    startTx(8'h42);
    giveToken();
    frameSent();
    replyAt(1'b1, T);
    chk("R8", "ack on last window cycle", sendData, 1'b1);
    chk("R8", "no pass", passToken, 1'b0);
    frameSent();
    replyAt(1'b1, 1);
    chk("R7", "status", statusOut, 4'b0011);
    tick();
  endtask

  task automatic t_enqTimeout();
    startTx(8'h07);
    giveToken();
    frameSent();
    tick(T - 1);
    chk("R8", "no pass before expiry", passToken, 1'b0);
    chk("R8", "status before expiry", statusOut, 4'b0000);
    tick();
    chk("R8", "pass on expiry", passToken, 1'b1);
    chk("R8", "status no response", statusOut, 4'b0101);
    chk("R8", "no data", sendData, 1'b0);
    tick();
  endtask

  task automatic t_dataTimeout();
    startTx(8'hC3);
    giveToken();
    frameSent();
    replyAt(1'b1, 1);
    chk("R5", "sendData", sendData, 1'b1);
    frameSent();
    tick(T - 1);
    chk("R8", "data no pass before expiry", passToken, 1'b0);
    tick();
    chk("R8", "data pass on expiry", passToken, 1'b1);
    chk("R8", "data status", statusOut, 4'b0101);
    tick();
  endtask

  task automatic t_busyIgnore();
    startTx(8'h22);
    txEnable = 1'b1; destId = 8'h77;
    tick();
    txEnable = 1'b0;
    chk("R2", "status unchanged", statusOut, 4'b0000);
    giveToken();
    chk("R2", "dest kept", frameDest, 8'h22);
    frameSent();
    replyAt(1'b0, 1);
    chk("R6", "status", statusOut, 4'b1001);
    tick();
  endtask

  task automatic t_collision();
    txEnable = 1'b1; destId = 8'h33; tokenIn = 1'b1;
    tick();
    txEnable = 1'b0; tokenIn = 1'b0;
    chk("R3", "collision passToken", passToken, 1'b1);
    chk("R3", "collision no enq", sendEnq, 1'b0);
    chk("R2", "collision accepted", statusOut[0], 1'b0);
    tick();
    giveToken();
    chk("R4", "pending enq", sendEnq, 1'b1);
    chk("R4", "pending dest", frameDest, 8'h33);
    frameSent();
    replyAt(1'b0, 1);
    tick();
  endtask

  task automatic t_stray();
    replyAck = 1'b1;
    tick();
    replyAck = 1'b0;
    chk("R10", "idle ack requests", {sendEnq, sendData, passToken}, 3'b000);
    chk("R10", "idle ack status", statusOut, 4'b1001);
    startTx(8'h66);
    giveToken();
    replyAck = 1'b1;
    tick();
    replyAck = 1'b0;
    chk("R10", "ack before frameDone", sendData, 1'b0);
    frameSent();
    replyAt(1'b0, 1);
    chk("R10", "window still opened", statusOut, 4'b1001);
    intMask = 4'b0001; #1;
    chk("R9", "irq avail", irq, 1'b1);
    intMask = 4'b0000;
    tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(3);
    rstN = 1'b1;
    tick();
    t_reset();
    t_idlePass();
    t_fullAck();
    t_enqNak();
    t_lastCycleAck();
    t_enqTimeout();
    t_dataTimeout();
    t_busyIgnore();
    t_collision();
    t_stray();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule